// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This block is a synchronous controller for an external multi-channel, simultaneous-sampling ADC that has a parallel data bus. After reset it gives the converter a reset pulse and a quiet gap. It then waits in idle. A start request latches the oversampling code and raises the conversion strobe for a minimum time. The block then waits for the converter's busy flag to rise and fall, and reads one word per channel with a chip-select and read-strobe burst. Each word goes out on a single-cycle valid output, together with its channel index.

Every pulse width and delay is a minimum count of system clocks. Each count is derived from a nanosecond limit and the clock period, both of which are parameters. The busy flag passes through a two-flop synchroniser. A watchdog checks two things. First, busy must rise soon after the conversion strobe. Second, the conversion must end within a limit that is chosen by the latched oversampling code. If either check fails, the block releases the bus, issues a new converter reset and returns to idle.

Top module: `adc_seq_top`

## Requirements
- R1: After system reset, `adc_reset_o` is high for at least 5 clocks (50 ns at 10 ns), and `cs_n_o`/`rd_n_o` are high with `convst_o` low. At least 3 clocks (25 ns) pass from the fall of `adc_reset_o` to the first rise of `convst_o`.
- R2: Every `convst_o` high pulse lasts at least 3 clocks, and it is preceded by at least 3 low clocks.
- R3: `os_o` follows `os_i` only while the block is idle and the synchronised busy flag is low. From the accepted start until the return to idle it holds the code captured at start, and it never changes while busy is high.
- R4: If synchronised busy has not been seen high within 8 clocks of the `convst_o` rise (45 ns plus synchroniser and sampling allowance), `fault_o` pulses 8 clocks after that rise.
- R5: After busy is first seen high, the conversion limit in clocks is ceil(T/period)+2. T comes from the latched code: 0→4150 ns, 1→9100, 2→18800, 3→39000, 4→78000, 5→158000, 6 and 7→315000. If busy is still high when the limit expires, `fault_o` pulses.
- R6: `cs_n_o` falls on the same edge as the first `rd_n_o` fall. That edge is the third clock edge after busy falls at the pin: two edges for the synchroniser and one for the decision. `rd_n_o` is low only while `cs_n_o` is low, and `cs_n_o` returns high when the burst ends.
- R7: Every `rd_n_o` low pulse lasts at least 4 clocks (37 ns). Inside a burst, every `rd_n_o` high gap lasts at least 2 clocks (15 ns).
- R8: `data_i` is sampled on the edge where `rd_n_o` rises. On the next cycle it appears on `word_o` with `word_vld_o` high for one cycle. `chan_o` takes the values 0 to N_CH-1 in order, one per strobe.
- R9: A start request is ignored unless the block is idle. A request during a conversion or burst produces no extra `convst_o` pulse, neither then nor later.
- R10: `done_o` is high for exactly one cycle per conversion, after the last channel word has been presented.
- R11: On a fault, `cs_n_o` and `rd_n_o` are high and `adc_reset_o` is high in the same cycle as `fault_o`. The reset pulse lasts at least 5 clocks, and the block then accepts new starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only in idle |
| os_i | input | 3 | Requested oversampling code |
| busy_i | input | 1 | Converter busy flag, asynchronous |
| data_i | input | DW | Converter parallel data bus |
| adc_reset_o | output | 1 | Converter reset, active high |
| convst_o | output | 1 | Conversion start strobe |
| os_o | output | 3 | Oversampling code driven to the converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| word_o | output | DW | Captured data word |
| word_vld_o | output | 1 | One-cycle valid for `word_o` |
| chan_o | output | CW | Channel index of `word_o` |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| fault_o | output | 1 | One-cycle busy-rise or conversion timeout fault |

## Verification
The checker makes three assumptions about the block's inputs. First, `busy_i` rises only in answer to a conversion strobe and falls once per conversion. Second, `data_i` stays stable for the whole time `rd_n_o` is low. Third, start requests are short pulses. The bench meets these assumptions with a converter model that runs on the falling clock edge. The model raises busy in the half cycle after it sees the strobe, holds busy for a fixed number of clocks and drives a new word after each read-strobe fall. The model can also withhold busy or leave it stuck high, and so trigger each watchdog path on purpose. The width and hold properties compare counters kept in the checker against the derived clock counts, so they hold for any legal busy timing the model produces.

// File: rtl/adc_seq_pkg.sv
// Shared types and timing arithmetic for the ADC sequencer.
// Assumes all limits are positive nanosecond values and the clock period is > 0.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST,    // converter reset high
        ST_GAP,    // quiet time after converter reset
        ST_IDLE,   // waiting for a start request
        ST_SETUP,  // oversampling setup and strobe low time
        ST_CVHI,   // conversion strobe high
        ST_CONV,   // waiting for busy to rise then fall
        ST_RDLO,   // read strobe low
        ST_RDHI    // read strobe high
    } seq_state_t;

    // Round a nanosecond limit up to whole clocks, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Worst-case conversion time for an oversampling code.
    function automatic int conv_limit_ns(input int code);
        case (code)
            0:       return 4150;
            1:       return 9100;
            2:       return 18800;
            3:       return 39000;
            4:       return 78000;
            5:       return 158000;
            default: return 315000;
        endcase
    endfunction

    // Watchdog length in clocks, including two synchroniser stages.
    function automatic int tmo_cyc(input int code, input int clk_ns);
        return ns2cyc(conv_limit_ns(code), clk_ns) + 2;
    endfunction

endpackage

// File: rtl/adc_sync2.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes the input changes no faster than the stage count allows.
module adc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d_i};
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/adc_down_cnt.sv
// Loadable down counter that stops at zero; done_o is high at zero.
// A load of value V keeps done_o low for V cycles after the load edge.
module adc_down_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt;

    // Load, count down or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= W'(RST_VAL);
        else if (load_i)      cnt <= val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/adc_chan_cnt.sv
// Channel index counter for the read burst: cleared at start, stepped per word.
// Assumes step is never issued when last_o is high.
module adc_chan_cnt #(
    parameter int N_CH = 8,
    localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [CW-1:0] idx_o,
    output logic          last_o
);
    // Track the channel being read.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_o <= '0;
        else if (clr_i)  idx_o <= '0;
        else if (step_i) idx_o <= idx_o + 1'b1;
    end

    assign last_o = (idx_o == CW'(N_CH - 1));
endmodule

// File: rtl/adc_seq_top.sv
// Sequencer for a parallel-bus simultaneous-sampling ADC.
// It resets the converter, strobes a conversion, waits on the synchronised busy
// flag with a watchdog, then reads N_CH words with one read strobe per word.
// Assumes busy_i is asynchronous and data_i is stable while rd_n_o is low.
module adc_seq_top #(
    parameter int CLK_NS    = 10,
    parameter int N_CH      = 8,
    parameter int DW        = 16,
    parameter int T_RST_NS  = 50,
    parameter int T_GAP_NS  = 25,
    parameter int T_CVLO_NS = 25,
    parameter int T_CVHI_NS = 25,
    parameter int T_OSSU_NS = 20,
    parameter int T_BUSY_NS = 45,
    parameter int T_RDLO_NS = 37,
    parameter int T_RDHI_NS = 15,
    localparam int CW       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    os_i,
    input  logic          busy_i,
    input  logic [DW-1:0] data_i,
    output logic          adc_reset_o,
    output logic          convst_o,
    output logic [2:0]    os_o,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic [DW-1:0] word_o,
    output logic          word_vld_o,
    output logic [CW-1:0] chan_o,
    output logic          done_o,
    output logic          fault_o
);
    import adc_seq_pkg::*;

    localparam int RST_CYC  = ns2cyc(T_RST_NS, CLK_NS);
    localparam int GAP_CYC  = ns2cyc(T_GAP_NS, CLK_NS);
    localparam int SU_CYC   = imax(ns2cyc(T_CVLO_NS, CLK_NS), ns2cyc(T_OSSU_NS, CLK_NS));
    localparam int CVHI_CYC = ns2cyc(T_CVHI_NS, CLK_NS);
    localparam int RISE_CYC = ns2cyc(T_BUSY_NS, CLK_NS) + 3;
    localparam int RDLO_CYC = ns2cyc(T_RDLO_NS, CLK_NS);
    localparam int RDHI_CYC = ns2cyc(T_RDHI_NS, CLK_NS);
    localparam int PH_MAX   = imax(imax(imax(RST_CYC, GAP_CYC), imax(SU_CYC, CVHI_CYC)),
                                   imax(RDLO_CYC, RDHI_CYC));
    localparam int PW       = $clog2(PH_MAX + 1);
    localparam int WD_MAX   = imax(tmo_cyc(7, CLK_NS), RISE_CYC);
    localparam int WDW      = $clog2(WD_MAX + 1);

    seq_state_t        state, nxt;
    logic              busy_s, seen;
    logic              ph_load, ph_done, wd_load, wd_done;
    logic [PW-1:0]     ph_val;
    logic [WDW-1:0]    wd_val;
    logic              ch_clr, ch_step, ch_last, cap, fin, flt;
    logic [CW-1:0]     ch_idx;
    logic [WDW-1:0]    tmo_tab [8];

    // One conversion-limit entry per oversampling code, computed from the clock.
    for (genvar g = 0; g < 8; g++) begin : g_tmo
        assign tmo_tab[g] = WDW'(tmo_cyc(g, CLK_NS) - 1);
    end

    adc_sync2 #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(busy_i), .q_o(busy_s)
    );

    adc_down_cnt #(.W(PW), .RST_VAL(RST_CYC - 1)) u_phase (
        .clk(clk), .rst_n(rst_n), .load_i(ph_load), .val_i(ph_val), .done_o(ph_done)
    );

    adc_down_cnt #(.W(WDW), .RST_VAL(0)) u_wdog (
        .clk(clk), .rst_n(rst_n), .load_i(wd_load), .val_i(wd_val), .done_o(wd_done)
    );

    adc_chan_cnt #(.N_CH(N_CH)) u_chan (
        .clk(clk), .rst_n(rst_n), .clr_i(ch_clr), .step_i(ch_step),
        .idx_o(ch_idx), .last_o(ch_last)
    );

    // Next state, timer loads and burst events.
    always_comb begin
        nxt     = state;
        ph_load = 1'b0;
        ph_val  = '0;
        wd_load = 1'b0;
        wd_val  = '0;
        ch_clr  = 1'b0;
        ch_step = 1'b0;
        cap     = 1'b0;
        fin     = 1'b0;
        flt     = 1'b0;
        case (state)
            ST_RST: if (ph_done) begin
                nxt = ST_GAP; ph_load = 1'b1; ph_val = PW'(GAP_CYC - 1);
            end
            ST_GAP: if (ph_done) nxt = ST_IDLE;
            ST_IDLE: if (start_i) begin
                nxt = ST_SETUP; ph_load = 1'b1; ph_val = PW'(SU_CYC - 1); ch_clr = 1'b1;
            end
            ST_SETUP: if (ph_done) begin
                nxt = ST_CVHI; ph_load = 1'b1; ph_val = PW'(CVHI_CYC - 1);
                wd_load = 1'b1; wd_val = WDW'(RISE_CYC - 1);
            end
            ST_CVHI: begin
                if (wd_done) flt = 1'b1;
                else begin
                    if (busy_s && !seen) begin
                        wd_load = 1'b1; wd_val = tmo_tab[os_o];
                    end
                    if (ph_done) nxt = ST_CONV;
                end
            end
            ST_CONV: begin
                if (wd_done) flt = 1'b1;
                else if (busy_s && !seen) begin
                    wd_load = 1'b1; wd_val = tmo_tab[os_o];
                end else if (seen && !busy_s) begin
                    nxt = ST_RDLO; ph_load = 1'b1; ph_val = PW'(RDLO_CYC - 1);
                end
            end
            ST_RDLO: if (ph_done) begin
                cap = 1'b1; nxt = ST_RDHI; ph_load = 1'b1; ph_val = PW'(RDHI_CYC - 1);
            end
            ST_RDHI: if (ph_done) begin
                if (ch_last) begin
                    fin = 1'b1; nxt = ST_IDLE;
                end else begin
                    ch_step = 1'b1; nxt = ST_RDLO;
                    ph_load = 1'b1; ph_val = PW'(RDLO_CYC - 1);
                end
            end
            default: nxt = ST_RST;
        endcase
        if (flt) begin
            nxt = ST_RST; ph_load = 1'b1; ph_val = PW'(RST_CYC - 1);
        end
    end

    // State register and busy-seen flag for the current conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RST;
            seen  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_SETUP) seen <= 1'b0;
            else if ((state == ST_CVHI || state == ST_CONV) && busy_s) seen <= 1'b1;
        end
    end

    // Registered converter controls decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_reset_o <= 1'b1;
            convst_o    <= 1'b0;
            cs_n_o      <= 1'b1;
            rd_n_o      <= 1'b1;
            done_o      <= 1'b0;
            fault_o     <= 1'b0;
        end else begin
            adc_reset_o <= (nxt == ST_RST);
            convst_o    <= (nxt == ST_CVHI);
            cs_n_o      <= !(nxt == ST_RDLO || nxt == ST_RDHI);
            rd_n_o      <= (nxt != ST_RDLO);
            done_o      <= fin;
            fault_o     <= flt;
        end
    end

    // Oversampling code tracks the request only while idle with busy low.
    always_ff @(posedge clk) begin
        if (!rst_n)                          os_o <= '0;
        else if (state == ST_IDLE && !busy_s) os_o <= os_i;
    end

    // Capture the bus on the read-strobe rising edge and present it with its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld_o <= 1'b0;
            word_o     <= '0;
            chan_o     <= '0;
        end else begin
            word_vld_o <= cap;
            if (cap) begin
                word_o <= data_i;
                chan_o <= ch_idx;
            end
        end
    end
endmodule

// File: rtl/adc_seq_chk.sv
// Timing and protocol checker for adc_seq_top, attached by bind.
// Assumes the cycle counts given are those the top derived for itself.
module adc_seq_chk #(
    parameter int N_CH     = 8,
    parameter int RST_CYC  = 5,
    parameter int SU_CYC   = 3,
    parameter int CVHI_CYC = 3,
    parameter int RDLO_CYC = 4,
    parameter int RDHI_CYC = 2,
    localparam int CW      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adc_reset_o,
    input logic          convst_o,
    input logic [2:0]    os_o,
    input logic          cs_n_o,
    input logic          rd_n_o,
    input logic          busy_s,
    input logic          word_vld_o,
    input logic [CW-1:0] chan_o,
    input logic          done_o,
    input logic          fault_o
);
    logic [15:0] lo_run, hi_run, cvhi_run, cvlo_run, rst_run;

    // Run-length counters of each control level, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0; hi_run <= '0; cvhi_run <= '0; cvlo_run <= '0; rst_run <= '0;
        end else begin
            lo_run   <= rd_n_o ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
            hi_run   <= (!rd_n_o || cs_n_o) ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
            cvhi_run <= !convst_o ? '0 : ((cvhi_run == '1) ? cvhi_run : cvhi_run + 1'b1);
            cvlo_run <= convst_o ? '0 : ((cvlo_run == '1) ? cvlo_run : cvlo_run + 1'b1);
            rst_run  <= !adc_reset_o ? '0 : ((rst_run == '1) ? rst_run : rst_run + 1'b1);
        end
    end

    // R1
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_reset_o) |-> rst_run >= 16'(RST_CYC));
    // R2
    cv_hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_o) |-> cvhi_run >= 16'(CVHI_CYC));
    // R2
    cv_lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_o) |-> cvlo_run >= 16'(SU_CYC));
    // R3
    os_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_s |-> $stable(os_o));
    // R6
    rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);
    // R7
    rd_lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n_o) |-> lo_run >= 16'(RDLO_CYC));
    // R7
    rd_hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n_o) && $past(!cs_n_o)) |-> hi_run >= 16'(RDHI_CYC));
    // R8
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> chan_o <= CW'(N_CH - 1));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (adc_reset_o && cs_n_o && rd_n_o));
endmodule

bind adc_seq_top adc_seq_chk #(
    .N_CH(N_CH), .RST_CYC(RST_CYC), .SU_CYC(SU_CYC), .CVHI_CYC(CVHI_CYC),
    .RDLO_CYC(RDLO_CYC), .RDHI_CYC(RDHI_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_reset_o(adc_reset_o), .convst_o(convst_o),
    .os_o(os_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .busy_s(busy_s),
    .word_vld_o(word_vld_o), .chan_o(chan_o), .done_o(done_o), .fault_o(fault_o)
);

// File: tb/sim_adc_seq_top.sv
// Directed bench for adc_seq_top with a falling-edge converter model.
module sim_adc_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int RST_REQ    = 5;
    localparam int GAP_REQ    = 3;
    localparam int CV_REQ     = 3;
    localparam int RDLO_REQ   = 4;
    localparam int RDHI_REQ   = 2;
    localparam int RISE_DLY   = 8;
    localparam int TMO_OS0    = 417;
    localparam int TMO_OS1    = 912;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  os_i = 3'd0;
    logic        busy_i = 1'b0;
    logic [15:0] data_i = 16'h0;
    logic        adc_reset_o, convst_o, cs_n_o, rd_n_o, word_vld_o, done_o, fault_o;
    logic [2:0]  os_o;
    logic [15:0] word_o;
    logic [2:0]  chan_o;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .os_i(os_i), .busy_i(busy_i),
        .data_i(data_i), .adc_reset_o(adc_reset_o), .convst_o(convst_o), .os_o(os_o),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .word_o(word_o), .word_vld_o(word_vld_o),
        .chan_o(chan_o), .done_o(done_o), .fault_o(fault_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: 0 normal, 1 never busy, 2 busy stuck high.
    int          m_mode = 0, m_len = 50, m_left = 0, m_idx = 0;
    bit          m_release = 1'b0, m_cv_prev = 1'b0, m_rd_prev = 1'b1;
    logic [15:0] m_base = 16'h0;
    int          busy_rise_cyc = 0, busy_fall_cyc = 0;
    always @(negedge clk) begin
        if (m_release) busy_i = 1'b0;
        if (convst_o && !m_cv_prev) begin
            m_idx = 0;
            if (m_mode != 1) begin
                busy_i = 1'b1; m_left = m_len; busy_rise_cyc = cyc;
            end
        end else if (busy_i && m_mode == 0) begin
            if (m_left <= 1) begin busy_i = 1'b0; busy_fall_cyc = cyc; end
            else m_left = m_left - 1;
        end
        if (!rd_n_o && m_rd_prev) begin
            data_i = m_base + 16'(m_idx) * 16'h0101;
            m_idx = m_idx + 1;
        end
        m_cv_prev = convst_o;
        m_rd_prev = rd_n_o;
    end

    // Monitor: words, events and minimum observed widths.
    logic [15:0] got_w [NCH];
    int          got_c [NCH];
    int nwords = 0, done_cnt = 0, cv_rises = 0, cv_rise_cyc = 0, fault_cyc = 0, fault_cnt = 0;
    int cs_fall_cyc = 0, rst_fall_cyc = 0;
    bit fault_rel_ok = 1'b1, first_cv = 1'b1;
    int run_rdlo = 0, run_rdhi = 0, run_cvhi = 0, run_cvlo = 0, run_rst = 0;
    int min_rdlo = 999, min_rdhi = 999, min_cvhi = 999, min_cvlo = 999, min_rst = 999, min_gap = 999;
    bit p_rd = 1'b1, p_cs = 1'b1, p_cv = 1'b0, p_rst = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_vld_o && nwords < NCH) begin
                got_w[nwords] = word_o; got_c[nwords] = int'(chan_o); nwords++;
            end
            if (done_o) done_cnt++;
            if (fault_o) begin
                fault_cnt++; fault_cyc = cyc;
                if (!(adc_reset_o && cs_n_o && rd_n_o)) fault_rel_ok = 1'b0;
            end
            if (!cs_n_o && p_cs) cs_fall_cyc = cyc;
            if (rd_n_o && !p_rd && run_rdlo < min_rdlo) min_rdlo = run_rdlo;
            if (!rd_n_o && p_rd && !p_cs && run_rdhi < min_rdhi) min_rdhi = run_rdhi;
            if (!convst_o && p_cv && run_cvhi < min_cvhi) min_cvhi = run_cvhi;
            if (convst_o && !p_cv) begin
                cv_rises++; cv_rise_cyc = cyc;
                if (run_cvlo < min_cvlo) min_cvlo = run_cvlo;
                if (first_cv && cyc - rst_fall_cyc < min_gap) min_gap = cyc - rst_fall_cyc;
                first_cv = 1'b0;
            end
            if (!adc_reset_o && p_rst) begin
                rst_fall_cyc = cyc; first_cv = 1'b1;
                if (run_rst < min_rst) min_rst = run_rst;
            end
            run_rdlo = rd_n_o ? 0 : run_rdlo + 1;
            run_rdhi = (rd_n_o && !cs_n_o) ? run_rdhi + 1 : 0;
            run_cvhi = convst_o ? run_cvhi + 1 : 0;
            run_cvlo = convst_o ? 0 : run_cvlo + 1;
            run_rst  = adc_reset_o ? run_rst + 1 : 0;
        end
        p_rd = rd_n_o; p_cs = cs_n_o; p_cv = convst_o; p_rst = adc_reset_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nwords = 0; done_cnt = 0; cv_rises = 0; fault_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic wait_fault(input int limit);
        for (int i = 0; i < limit && fault_cnt == 0; i++) @(negedge clk);
    endtask

    // R1: reset state and converter reset pulse after system reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_reset_o == 1'b1, "R1 adc_reset high after reset", int'(adc_reset_o), 1);
        check(cs_n_o && rd_n_o && !convst_o, "R1 bus idle after reset",
              int'({cs_n_o, rd_n_o, convst_o}), 6);
        repeat (15) @(negedge clk);
        check(adc_reset_o == 1'b0, "R1 adc_reset released", int'(adc_reset_o), 0);
        check(min_rst >= RST_REQ, "R1 reset pulse width", min_rst, RST_REQ);
    endtask

    // R6 R8 R9 R10: one conversion and burst, optionally with an ignored start.
    task automatic t_conv(input logic [2:0] os, input logic [15:0] base, input bit extra);
        clear_mon();
        m_mode = 0; m_base = base; os_i = os;
        pulse_start();
        if (extra) begin
            repeat (20) @(negedge clk);
            pulse_start();
        end
        wait_done(3000);
        check(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
        check(nwords == NCH, "R8 word count", nwords, NCH);
        for (int i = 0; i < NCH; i++) begin
            check(got_c[i] == i, "R8 channel order", got_c[i], i);
            check(got_w[i] == base + 16'(i) * 16'h0101, "R8 word value",
                  int'(got_w[i]), int'(base + 16'(i) * 16'h0101));
        end
        check(cs_fall_cyc - busy_fall_cyc == 3, "R6 cs fall after busy fall",
              cs_fall_cyc - busy_fall_cyc, 3);
        repeat (2) @(negedge clk);
        check(cs_n_o == 1'b1, "R6 cs released after burst", int'(cs_n_o), 1);
        repeat (50) @(negedge clk);
        check(cv_rises == 1, "R9 start during conversion ignored", cv_rises, 1);
        check(done_cnt == 1, "R10 no extra done", done_cnt, 1);
    endtask

    // R3: code latched at start, request change only taken in idle.
    task automatic t_os_latch();
        clear_mon();
        m_mode = 0; m_base = 16'h1200; os_i = 3'd3;
        pulse_start();
        repeat (6) @(negedge clk);
        os_i = 3'd5;
        repeat (20) @(negedge clk);
        check(os_o == 3'd3, "R3 code held during conversion", int'(os_o), 3);
        wait_done(3000);
        repeat (3) @(negedge clk);
        check(os_o == 3'd5, "R3 code follows request in idle", int'(os_o), 5);
    endtask

    // R2 R7 R1: minimum widths over all strobes seen.
    task automatic t_widths();
        check(min_cvhi >= CV_REQ, "R2 convst high width", min_cvhi, CV_REQ);
        check(min_cvlo >= CV_REQ, "R2 convst low width", min_cvlo, CV_REQ);
        check(min_rdlo >= RDLO_REQ, "R7 rd low width", min_rdlo, RDLO_REQ);
        check(min_rdhi >= RDHI_REQ, "R7 rd high width", min_rdhi, RDHI_REQ);
        check(min_gap >= GAP_REQ, "R1 reset to convst gap", min_gap, GAP_REQ);
    endtask

    // R4 R11: busy never rises.
    task automatic t_no_busy();
        clear_mon();
        m_mode = 1; os_i = 3'd0;
        pulse_start();
        wait_fault(200);
        check(fault_cnt == 1, "R4 fault raised", fault_cnt, 1);
        check(fault_cyc - cv_rise_cyc == RISE_DLY, "R4 fault delay",
              fault_cyc - cv_rise_cyc, RISE_DLY);
        check(fault_rel_ok, "R11 bus released on fault", int'(fault_rel_ok), 1);
        repeat (20) @(negedge clk);
        check(min_rst >= RST_REQ, "R11 reset pulse after fault", min_rst, RST_REQ);
        m_mode = 0;
        t_conv(3'd0, 16'h5A00, 1'b0);
    endtask

    // R5 R11: busy stuck high, limit chosen by latched code.
    task automatic t_timeout(input logic [2:0] os, input int tmo);
        clear_mon();
        m_mode = 2; os_i = os;
        pulse_start();
        wait_fault(tmo + 100);
        check(fault_cnt == 1, "R5 timeout fault", fault_cnt, 1);
        check(fault_cyc - busy_rise_cyc >= tmo && fault_cyc - busy_rise_cyc <= tmo + 5,
              "R5 timeout length", fault_cyc - busy_rise_cyc, tmo + 3);
        check(fault_rel_ok, "R11 bus released on timeout", int'(fault_rel_ok), 1);
        m_release = 1'b1;
        repeat (2) @(negedge clk);
        m_release = 1'b0; m_mode = 0;
        repeat (20) @(negedge clk);
    endtask

    bit finished = 1'b0;
    initial begin
        t_reset();
        t_conv(3'd0, 16'h0100, 1'b0);
        t_conv(3'd2, 16'hA000, 1'b1);
        t_os_latch();
        t_widths();
        t_no_busy();
        t_timeout(3'd0, TMO_OS0);
        t_timeout(3'd1, TMO_OS1);
        t_conv(3'd4, 16'h3300, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule